// File: doc/BRIEF.md
# Sequential Garbage-Collection Victim Selector

This block decides which erase block a flash translation layer controller reclaims next. Wear leveling and garbage collection happen in one step. The block keeps a small invalid-page counter for every erase block. It also keeps one "heavily stale" bit per block, which is set once more than three quarters of that block's pages have been invalidated, and a running tally of how many of those bits are set. The invalidation bookkeeping happens during ordinary write traffic, whenever a page is superseded.

The controller reports its free-block count continuously. Whenever the selector is idle and that count equals exactly one, it picks a victim. If any stale bit is set, it scans the stale bits from its own wrapping scan index, testing one block per clock, and takes the first stale block it meets. If no stale bit is set, it takes the block under a wrapping sequential pointer and advances that pointer, so erases rotate across the whole device. No erase-count table is kept, and no tunable threshold exists. The victim index is held with a valid strobe until the controller signals that the erase has finished. The erase then clears that block's counter and stale bit.

Top module: `gcsel_victim_top`

## Requirements
- R1: After reset, `victim_valid` is low, every invalid counter and stale bit is zero, and both the sequential pointer and the scan index are at block 0.
- R2: A block's stale bit sets on the invalidation that takes its invalid count strictly above 48 (the 49th with 64 pages per block), and is clear at 48 or fewer.
- R3: The tally of set stale bits chooses the policy. While the tally is nonzero the victim is a stale block. While it is zero the victim is the sequential block.
- R4: A selection starts only when the selector is idle and `free_blocks` equals exactly 1. Values of 0 or 2 and above start nothing.
- R5: With no stale bits set, the victim is the sequential pointer's block. The pointer then advances by one and wraps from block 63 to block 0. Stale-bit picks do not move it.
- R6: With stale bits set, the scan begins at the scan index and moves upward with wrap-around. It picks the first stale block it finds. The scan index is then left one position past that victim.
- R7: `victim_valid` stays high and `victim_block` stays unchanged until `erase_done` is seen. No new selection starts while a victim is outstanding, and `erase_done` has no effect while `victim_valid` is low.
- R8: When `erase_done` is seen for the victim, that block's invalid counter and stale bit clear. A later set of the stale bit then needs 49 fresh invalidations.
- R9: If one block's stale bit sets in the same cycle that an erase clears another block's stale bit, the tally is unchanged. An invalidation aimed at the block being erased in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_valid | input | 1 | A page in `inv_block` has been invalidated this cycle |
| inv_block | input | 6 | Block index of the invalidated page |
| free_blocks | input | 8 | Current number of free erase blocks |
| erase_done | input | 1 | The erase of the held victim has finished |
| victim_valid | output | 1 | A victim is selected and waiting for its erase |
| victim_block | output | 6 | Index of the selected victim block |

## Verification
Every internal fault in this block surfaces as a wrong or missing victim index at the next selection that depends on it. A miscounted stale tally either picks a sequential block while stale blocks wait, or leaves the scan circling with no stale bit to find. The second case shows as `victim_valid` never rising within a bounded number of cycles. An uncleared counter or stale bit after an erase, or an invalidation that should have been dropped, shows later: the block becomes stale too early and wins a selection it should lose. A sequential pointer or scan index that is off by one shows at once as the wrong victim on the very next pick of that policy.

// File: rtl/gcsel_pkg.sv
package gcsel_pkg;

    localparam int unsigned GCSEL_BLOCKS_DEF = 64;
    localparam int unsigned GCSEL_PAGES_DEF  = 64;
    localparam int unsigned GCSEL_FREE_W_DEF = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } sel_state_e;

    // stale threshold: three quarters of the pages in a block
    function automatic int unsigned stale_limit(input int unsigned pages);
        return (pages * 3) / 4;
    endfunction

endpackage

// File: rtl/gcsel_wear_track.sv
module gcsel_wear_track
    import gcsel_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS      = GCSEL_BLOCKS_DEF,
    parameter int unsigned PAGES_PER_BLOCK = GCSEL_PAGES_DEF,
    localparam int unsigned BW = $clog2(NUM_BLOCKS),
    localparam int unsigned CW = $clog2(PAGES_PER_BLOCK + 1),
    localparam int unsigned TW = $clog2(NUM_BLOCKS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  inv_valid,
    input  logic [BW-1:0]         inv_block,
    input  logic                  erase_en,
    input  logic [BW-1:0]         erase_blk,
    output logic [NUM_BLOCKS-1:0] stale,
    output logic                  tally_nz
);

    localparam int unsigned LIMIT = stale_limit(PAGES_PER_BLOCK);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);
    localparam logic [CW-1:0] FULL_C  = CW'(PAGES_PER_BLOCK);

    logic [CW-1:0] cnt [NUM_BLOCKS];
    logic [TW-1:0] tally;
    logic          inv_hit;
    logic          set_evt;
    logic          clr_evt;

    // invalidation counts only if in range and not aimed at the block being erased
    always_comb begin
        inv_hit = inv_valid && (32'(inv_block) < NUM_BLOCKS)
                  && !(erase_en && inv_block == erase_blk);
        set_evt = 1'b0;
        if (inv_hit) begin
            set_evt = !stale[inv_block] && (cnt[inv_block] >= LIMIT_C)
                      && (cnt[inv_block] < FULL_C);
        end
        clr_evt = erase_en && stale[erase_blk];
    end

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[i]   <= '0;
                stale[i] <= 1'b0;
            end else if (erase_en && erase_blk == BW'(i)) begin
                cnt[i]   <= '0;
                stale[i] <= 1'b0;
            end else if (inv_hit && inv_block == BW'(i) && cnt[i] < FULL_C) begin
                cnt[i] <= cnt[i] + 1'b1;
                if (cnt[i] >= LIMIT_C)
                    stale[i] <= 1'b1;
            end
        end

        // R2
        stale_needs_count_chk: assert property (@(posedge clk) disable iff (rst)
            stale[i] |-> (cnt[i] > LIMIT_C));
    end

    always_ff @(posedge clk) begin
        if (rst)
            tally <= '0;
        else if (set_evt && !clr_evt)
            tally <= tally + 1'b1;
        else if (clr_evt && !set_evt)
            tally <= tally - 1'b1;
    end

    assign tally_nz = (tally != '0);

    // R3
    tally_match_chk: assert property (@(posedge clk) disable iff (rst)
        32'(tally) == 32'($countones(stale)));

    // R8
    erase_clears_chk: assert property (@(posedge clk) disable iff (rst)
        erase_en |=> (stale[$past(erase_blk)] == 1'b0));

endmodule

// File: rtl/gcsel_pick.sv
module gcsel_pick
    import gcsel_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = GCSEL_BLOCKS_DEF,
    localparam int unsigned BW = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  trigger,
    input  logic                  tally_nz,
    input  logic [NUM_BLOCKS-1:0] stale,
    input  logic                  erase_done,
    output logic                  victim_valid,
    output logic [BW-1:0]         victim_block,
    output logic                  erase_en,
    output logic [BW-1:0]         erase_blk
);

    localparam logic [BW-1:0] LAST = BW'(NUM_BLOCKS - 1);

    sel_state_e    state;
    logic [BW-1:0] seq_ptr;
    logic [BW-1:0] scan_ptr;
    logic [BW-1:0] victim_q;

    function automatic logic [BW-1:0] wrap_inc(input logic [BW-1:0] v);
        return (v == LAST) ? '0 : v + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            seq_ptr  <= '0;
            scan_ptr <= '0;
            victim_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (trigger) begin
                        if (tally_nz) begin
                            state <= ST_SCAN;
                        end else begin
                            victim_q <= seq_ptr;
                            seq_ptr  <= wrap_inc(seq_ptr);
                            state    <= ST_HOLD;
                        end
                    end
                end
                ST_SCAN: begin
                    if (stale[scan_ptr]) begin
                        victim_q <= scan_ptr;
                        state    <= ST_HOLD;
                    end
                    scan_ptr <= wrap_inc(scan_ptr);
                end
                ST_HOLD: begin
                    if (erase_done)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign victim_valid = (state == ST_HOLD);
    assign victim_block = victim_q;
    assign erase_en     = victim_valid && erase_done;
    assign erase_blk    = victim_q;

    // R7
    victim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && !erase_done) |=> (victim_valid && $stable(victim_block)));

    // R4
    idle_without_trigger_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !trigger) |=> !victim_valid && state == ST_IDLE);

    // R5
    seq_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && trigger && !tally_nz) |=>
            (victim_valid && victim_block == $past(seq_ptr)));

    // R6
    scan_pick_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN && stale[scan_ptr]) |=>
            (victim_valid && victim_block == $past(scan_ptr)));

    // R6
    scan_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN && !stale[scan_ptr]) |=> (state == ST_SCAN));

endmodule

// File: rtl/gcsel_victim_top.sv
module gcsel_victim_top
    import gcsel_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS      = GCSEL_BLOCKS_DEF,
    parameter int unsigned PAGES_PER_BLOCK = GCSEL_PAGES_DEF,
    parameter int unsigned FREE_W          = GCSEL_FREE_W_DEF,
    localparam int unsigned BW = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inv_valid,
    input  logic [BW-1:0]     inv_block,
    input  logic [FREE_W-1:0] free_blocks,
    input  logic              erase_done,
    output logic              victim_valid,
    output logic [BW-1:0]     victim_block
);

    logic [NUM_BLOCKS-1:0] stale;
    logic                  tally_nz;
    logic                  erase_en;
    logic [BW-1:0]         erase_blk;
    logic                  trigger;

    assign trigger = (free_blocks == FREE_W'(1));

    gcsel_wear_track #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .inv_valid (inv_valid),
        .inv_block (inv_block),
        .erase_en  (erase_en),
        .erase_blk (erase_blk),
        .stale     (stale),
        .tally_nz  (tally_nz)
    );

    gcsel_pick #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_pick (
        .clk          (clk),
        .rst          (rst),
        .trigger      (trigger),
        .tally_nz     (tally_nz),
        .stale        (stale),
        .erase_done   (erase_done),
        .victim_valid (victim_valid),
        .victim_block (victim_block),
        .erase_en     (erase_en),
        .erase_blk    (erase_blk)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !victim_valid);

endmodule

// File: tb/gcsel_victim_top_test.sv
module gcsel_victim_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inv_valid = 1'b0;
    logic [5:0] inv_block = '0;
    logic [7:0] free_blocks = 8'd5;
    logic       erase_done = 1'b0;
    logic       victim_valid;
    logic [5:0] victim_block;

    int checks = 0;
    int errors = 0;
    int seq_exp = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gcsel_victim_top uut (
        .clk          (clk),
        .rst          (rst),
        .inv_valid    (inv_valid),
        .inv_block    (inv_block),
        .free_blocks  (free_blocks),
        .erase_done   (erase_done),
        .victim_valid (victim_valid),
        .victim_block (victim_block)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic invalidate(input int blk, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            inv_valid = 1'b1;
            inv_block = 6'(blk);
        end
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    // raise the trigger and wait for a victim; returns 1 if one appeared
    task automatic wait_victim(input string req, output bit got);
        got = 1'b0;
        @(negedge clk);
        free_blocks = 8'd1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (victim_valid) begin
                got = 1'b1;
                break;
            end
        end
        free_blocks = 8'd5;
        check(req, int'(got), 1);
    endtask

    task automatic finish_erase();
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
    endtask

    task automatic pick_expect(input string req, input int exp);
        bit got;
        wait_victim(req, got);
        if (got) begin
            check(req, int'(victim_block), exp);
            finish_erase();
        end
    endtask

    task automatic pick_seq(input string req);
        pick_expect(req, seq_exp);
        seq_exp = (seq_exp + 1) % 64;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check("R1 valid low after reset", int'(victim_valid), 0);
    endtask

    task automatic test_no_trigger();
        free_blocks = 8'd0;
        repeat (8) @(negedge clk);
        check("R4 free=0 no pick", int'(victim_valid), 0);
        free_blocks = 8'd2;
        repeat (8) @(negedge clk);
        check("R4 free=2 no pick", int'(victim_valid), 0);
        free_blocks = 8'd5;
        @(negedge clk);
    endtask

    task automatic test_sequential_hold();
        bit got;
        pick_seq("R5 first sequential from reset");
        pick_seq("R5 second sequential");
        wait_victim("R7 hold pick", got);
        if (got) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check("R7 valid held", int'(victim_valid), 1);
                check("R7 block held", int'(victim_block), seq_exp);
            end
            finish_erase();
            seq_exp = (seq_exp + 1) % 64;
        end
        // stray erase_done while idle
        finish_erase();
        repeat (2) @(negedge clk);
        check("R7 stray erase no pick", int'(victim_valid), 0);
        pick_seq("R7 sequence intact after stray erase");
    endtask

    task automatic test_stale_policy();
        invalidate(10, 48);
        pick_seq("R2 48 invalid not stale");
        invalidate(10, 1);
        pick_expect("R2 49th invalid makes stale", 10);
        invalidate(20, 49);
        invalidate(5, 49);
        pick_expect("R6 scan from one past last victim", 20);
        pick_expect("R6 scan wraps", 5);
        pick_seq("R3 tally zero returns to sequential");
        invalidate(20, 48);
        pick_seq("R8 erased block counter cleared");
    endtask

    task automatic test_same_cycle();
        bit got;
        invalidate(40, 48);
        invalidate(30, 49);
        wait_victim("R9 stale pick before overlap", got);
        if (got) begin
            check("R9 stale pick", int'(victim_block), 30);
            inv_valid = 1'b1;
            inv_block = 6'd40;
            finish_erase();
            inv_valid = 1'b0;
        end
        pick_expect("R9 set and clear same cycle keeps tally", 40);
        pick_seq("R9 tally back to zero");
        wait_victim("R9 erase block pick", got);
        if (got) begin
            check("R9 sequential victim", int'(victim_block), seq_exp);
            inv_valid = 1'b1;
            inv_block = 6'(seq_exp);
            finish_erase();
            inv_valid = 1'b0;
            invalidate(seq_exp, 48);
            seq_exp = (seq_exp + 1) % 64;
        end
        pick_seq("R9 invalidate on erased block ignored");
    endtask

    task automatic test_wrap();
        int n;
        n = 64 - seq_exp + 2;
        for (int k = 0; k < n; k++)
            pick_seq("R5 sequential wrap");
        check("R5 pointer wrapped", seq_exp, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_no_trigger();
        test_sequential_hold();
        test_stale_policy();
        test_same_cycle();
        test_wrap();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule